// File: doc/BRIEF.md
# DRAM strobe-sequence cycle decoder

This block models the control side of an asynchronous, address-multiplexed dynamic memory. It runs on a fast system clock and samples the four active-low strobes: row strobe, column strobe, write enable and output enable. Each sample is compared with the one before it to find falling and rising edges. From the order of those edges and the levels of write enable and output enable, the block works out which kind of memory cycle the host is running. It latches the row and column addresses, keeps an internal refresh row counter, holds a small storage array so that reads return written data, and drives the data-out enable with the rules that apply to each cycle type.

It is meant as a self-checking companion to a memory controller under test. The cycle-type output tells which operation the strobe sequence amounted to. The error output pulses when the sequence is illegal or when the data bus is contended.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: When the row strobe falls while the column strobe is high, the row address is latched and the cycle type becomes row-only refresh (code 4) one clock later. The row register changes on no other event.
- R2: When the row strobe falls while the column strobe is already low and the column strobe was high at some point since the last row-strobe rise, the cycle type becomes column-before-row refresh (code 5). In that case, and in R6, the 9-bit refresh row counter advances by one and wraps from 511 to 0.
- R3: A column-strobe fall inside a row cycle with write enable high is a read (code 1). It loads the stored word into the data output. The data-out enable is high exactly while such a read is open, the column strobe is low and output enable is low. It drops one clock after either strobe rises.
- R4: A column-strobe fall inside a row cycle with write enable already low is an early write (code 2). It stores the data input at index {row[2:0], column[2:0]}, and the data-out enable stays low throughout.
- R5: A write-enable fall while a read is open is a read-modify-write (code 3). It stores the data input at the latched column. The data already on the output does not change.
- R6: If the row strobe rises while the column strobe stays low and then falls again, the cycle is a hidden refresh (code 6). The counter advances, and the data output and its enable keep their values.
- R7: While the row strobe stays low, each new column-strobe fall latches a new column in the same row (page mode).
- R8: A row-strobe rise returns the cycle type to standby (code 0) and invalidates the latched row.
- R9: A column-strobe fall while the row strobe is low and no row is latched (for example inside a refresh) raises the error output for exactly one clock. A column-strobe fall with the row strobe high raises no error.
- R10: If the data-out enable is high while the bus-busy input is high, the error output is raised on the following clock.
- R11: After reset the cycle type is standby, the data-out enable and error are low, and the refresh counter, the addresses, the data output and the storage array are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| din | input | 4 | Write data from host |
| bus_busy | input | 1 | Host is currently driving the data bus |
| dout | output | 4 | Read data |
| dout_en | output | 1 | Read data is driven |
| cyc_type | output | 3 | Current cycle classification |
| row_addr | output | 9 | Latched row address |
| col_addr | output | 9 | Latched column address |
| rfsh_row | output | 9 | Internal refresh row counter |
| seq_err | output | 1 | Sequence or contention error pulse |

## Verification
Several strobe orderings are run through the block: write enable low before or after the column-strobe fall, the column strobe low before the row-strobe fall, and the column strobe held across a row-strobe rise. Each ordering tells the early write, the read-modify-write, the column-before-row refresh and the hidden refresh apart. Output enable is toggled during an open read, which separates enable-gated driving from strobe-gated driving. A page-mode run with several columns in one row checks that each column is latched on its own. A long series of refreshes takes the counter through its wrap. A column-strobe toggle inside a refresh and a bus collision during a hidden refresh exercise the error path.

// File: rtl/dram_seq_pkg.sv
// Shared cycle classification for the strobe-sequence decoder.
package dram_seq_pkg;
    typedef enum logic [2:0] {
        CY_IDLE   = 3'd0,
        CY_READ   = 3'd1,
        CY_EWR    = 3'd2,
        CY_RMW    = 3'd3,
        CY_RONLY  = 3'd4,
        CY_CBR    = 3'd5,
        CY_HIDDEN = 3'd6
    } cyc_e;
endpackage

// File: rtl/strobe_edges.sv
// Edge finder: registers each strobe sample and reports the falling and rising
// edges seen between the previous and the current sample. Assumes strobes are
// already synchronous to clk. Resets to the inactive (high) level.
module strobe_edges #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // keep the previous sample of one strobe
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b1;
            else        prev_q[i] <= lvl[i];
        end
        assign fall[i] = prev_q[i] & ~lvl[i];
        assign rise[i] = ~prev_q[i] & lvl[i];
    end
endmodule

// File: rtl/cell_store.sv
// Small storage array with one synchronous write port and one combinational
// read port. Cleared by reset. Assumes the index width is small.
module cell_store #(
    parameter int IDX_W = 6,
    parameter int DW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    localparam int DEPTH = 1 << IDX_W;
    logic [DW-1:0] mem [DEPTH];

    // clear on reset, otherwise perform a single write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/seq_ctrl.sv
// Sequence controller: classifies the cycle from strobe edges and levels,
// latches addresses, counts refresh rows, controls writes and the output
// driver and flags errors. Assumes edges arrive from strobe_edges with the
// bit order {oe, we, cas, ras}.
module seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 4,
    parameter int MR = 3,
    parameter int MC = 3,
    parameter int RW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       fall,
    input  logic [3:0]       rise,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [AW-1:0]    addr,
    input  logic             bus_busy,
    input  logic [DW-1:0]    rd_data,
    output logic             wr_en,
    output logic [MR+MC-1:0] wr_idx,
    output logic [MR+MC-1:0] rd_idx,
    output logic [DW-1:0]    dout,
    output logic             dout_en,
    output cyc_e             cyc,
    output logic [AW-1:0]    row_addr,
    output logic [AW-1:0]    col_addr,
    output logic [RW-1:0]    rfsh_row,
    output logic             seq_err
);
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic row_ok, carry, drv_ok;
    logic col_strobe, ew_hit, rd_hit, late_we, drv_nx;

    assign ras_fall = fall[0];
    assign ras_rise = rise[0];
    assign cas_fall = fall[1];
    assign cas_rise = rise[1];
    assign we_fall  = fall[2];

    assign col_strobe = cas_fall & ~ras_n & row_ok;
    assign ew_hit     = col_strobe & ~we_n;
    assign rd_hit     = col_strobe & we_n;
    assign late_we    = we_fall & ~cas_n & ~ras_n & row_ok & ~cas_fall & (cyc == CY_READ);
    assign drv_nx     = rd_hit ? 1'b1 : (cas_rise ? 1'b0 : drv_ok);

    assign wr_en  = ew_hit | late_we;
    assign wr_idx = ew_hit ? {row_addr[MR-1:0], addr[MC-1:0]}
                           : {row_addr[MR-1:0], col_addr[MC-1:0]};
    assign rd_idx = {row_addr[MR-1:0], addr[MC-1:0]};

    // cycle classification, address latches and refresh counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc      <= CY_IDLE;
            row_ok   <= 1'b0;
            carry    <= 1'b0;
            row_addr <= '0;
            col_addr <= '0;
            rfsh_row <= '0;
            dout     <= '0;
        end else begin
            if (ras_fall) begin
                if (cas_n) begin
                    row_addr <= addr;
                    row_ok   <= 1'b1;
                    cyc      <= CY_RONLY;
                end else begin
                    cyc      <= carry ? CY_HIDDEN : CY_CBR;
                    rfsh_row <= rfsh_row + 1'b1;
                    row_ok   <= 1'b0;
                end
            end
            if (ras_rise) begin
                cyc    <= CY_IDLE;
                row_ok <= 1'b0;
                if (!cas_n) carry <= 1'b1;
            end
            if (cas_rise) carry <= 1'b0;
            if (col_strobe) begin
                col_addr <= addr;
                cyc      <= we_n ? CY_READ : CY_EWR;
            end
            if (rd_hit) dout <= rd_data;
            if (late_we) cyc <= CY_RMW;
        end
    end

    // output driver permission and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_ok  <= 1'b0;
            dout_en <= 1'b0;
            seq_err <= 1'b0;
        end else begin
            drv_ok  <= drv_nx;
            dout_en <= drv_nx & ~oe_n & ~cas_n;
            seq_err <= (cas_fall & ~ras_n & ~row_ok) | (dout_en & bus_busy);
        end
    end
endmodule

// File: rtl/strobe_cycle_decoder.sv
// Top level: clock-sampled decoder of an asynchronous memory's strobe
// sequence. Assumes all strobes are synchronous to clk and change at most
// once per sample. Storage holds 2**(MR+MC) words indexed by low row/column bits.
module strobe_cycle_decoder #(
    parameter int AW = 9,
    parameter int DW = 4,
    parameter int MR = 3,
    parameter int MC = 3,
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          bus_busy,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic [2:0]    cyc_type,
    output logic [AW-1:0] row_addr,
    output logic [AW-1:0] col_addr,
    output logic [RW-1:0] rfsh_row,
    output logic          seq_err
);
    import dram_seq_pkg::*;
    localparam int IDX_W = MR + MC;

    logic [3:0]       fall, rise;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [DW-1:0]    rd_data;
    cyc_e             cyc;

    strobe_edges #(.N(4)) u_edges (
        .clk(clk), .rst_n(rst_n),
        .lvl({oe_n, we_n, cas_n, ras_n}),
        .fall(fall), .rise(rise)
    );

    cell_store #(.IDX_W(IDX_W), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(din),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    seq_ctrl #(.AW(AW), .DW(DW), .MR(MR), .MC(MC), .RW(RW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .bus_busy(bus_busy), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx),
        .dout(dout), .dout_en(dout_en), .cyc(cyc),
        .row_addr(row_addr), .col_addr(col_addr),
        .rfsh_row(rfsh_row), .seq_err(seq_err)
    );

    assign cyc_type = cyc;
endmodule

// File: rtl/dram_seq_chk.sv
// Checker bound to the decoder top: temporal properties on its ports.
module dram_seq_chk #(
    parameter int AW = 9,
    parameter int DW = 4,
    parameter int RW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cas_n,
    input logic          bus_busy,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic [2:0]    cyc_type,
    input logic [AW-1:0] row_addr,
    input logic [RW-1:0] rfsh_row,
    input logic          seq_err
);
    // R4
    ewr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == 3'd2) |-> !dout_en);
    // R3
    drive_needs_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!cas_n));
    // R2
    rfsh_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_row != $past(rfsh_row)) |->
        ((rfsh_row == RW'($past(rfsh_row) + 1'b1)) && (cyc_type == 3'd5 || cyc_type == 3'd6)));
    // R10
    busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && bus_busy) |=> seq_err);
    // R1
    row_only_on_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_addr != $past(row_addr)) |-> (cyc_type == 3'd4));
    // R6
    hidden_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == 3'd6) |-> $stable(dout));
endmodule

bind strobe_cycle_decoder dram_seq_chk #(.AW(AW), .DW(DW), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .bus_busy(bus_busy),
    .dout(dout), .dout_en(dout_en), .cyc_type(cyc_type),
    .row_addr(row_addr), .rfsh_row(rfsh_row), .seq_err(seq_err)
);

// File: tb/sim_strobe_cycle_decoder.sv
module sim_strobe_cycle_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [8:0] addr = '0;
    logic [3:0] din = '0;
    logic bus_busy = 1'b0;
    logic [3:0] dout;
    logic dout_en, seq_err;
    logic [2:0] cyc_type;
    logic [8:0] row_addr, col_addr, rfsh_row;

    int checks = 0, fails = 0, cycles = 0;
    bit armed = 0, done = 0;

    always #2 clk = ~clk;

    strobe_cycle_decoder u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .bus_busy(bus_busy),
        .dout(dout), .dout_en(dout_en), .cyc_type(cyc_type),
        .row_addr(row_addr), .col_addr(col_addr), .rfsh_row(rfsh_row),
        .seq_err(seq_err)
    );

    // behavioural reference model, updated on every clock
    int m_cyc, m_dout, m_en, m_row, m_col, m_rf, m_err;
    bit m_rowv, m_carry, m_open;
    int m_pr, m_pc, m_pw;
    int mem [64];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_dout = 0; m_en = 0; m_row = 0; m_col = 0; m_rf = 0; m_err = 0;
            m_rowv = 0; m_carry = 0; m_open = 0; m_pr = 1; m_pc = 1; m_pw = 1;
            foreach (mem[i]) mem[i] = 0;
        end else begin
            bit rf, rr, cf, cr, wf, old_rowv, old_en;
            rf = (m_pr == 1) && (ras_n == 0);
            rr = (m_pr == 0) && (ras_n == 1);
            cf = (m_pc == 1) && (cas_n == 0);
            cr = (m_pc == 0) && (cas_n == 1);
            wf = (m_pw == 1) && (we_n == 0);
            old_rowv = m_rowv;
            old_en = (m_en != 0);
            m_err = (cf && ras_n == 0 && !old_rowv) || (old_en && bus_busy);
            if (rf) begin
                if (cas_n) begin m_row = addr; m_rowv = 1; m_cyc = 4; end
                else begin m_cyc = m_carry ? 6 : 5; m_rf = (m_rf + 1) % 512; m_rowv = 0; end
            end
            if (rr) begin
                m_cyc = 0; m_rowv = 0;
                if (cas_n == 0) m_carry = 1;
            end
            if (cr) begin m_carry = 0; m_open = 0; end
            if (cf && ras_n == 0 && old_rowv) begin
                m_col = addr;
                if (we_n == 0) begin
                    m_cyc = 2;
                    mem[(m_row % 8) * 8 + (addr % 8)] = din;
                end else begin
                    m_cyc = 1; m_open = 1;
                    m_dout = mem[(m_row % 8) * 8 + (addr % 8)];
                end
            end else if (wf && cas_n == 0 && ras_n == 0 && old_rowv && m_cyc == 1) begin
                m_cyc = 3;
                mem[(m_row % 8) * 8 + (m_col % 8)] = din;
            end
            m_en = (m_open && oe_n == 0 && cas_n == 0) ? 1 : 0;
            m_pr = ras_n; m_pc = cas_n; m_pw = we_n;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (armed && !done) begin
            chk("R1 cyc_type", int'(cyc_type), m_cyc);
            chk("R1 row_addr", int'(row_addr), m_row);
            chk("R7 col_addr", int'(col_addr), m_col);
            chk("R3 dout", int'(dout), m_dout);
            chk("R3 dout_en", int'(dout_en), m_en);
            chk("R2 rfsh_row", int'(rfsh_row), m_rf);
            chk("R9 seq_err", int'(seq_err), m_err);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        armed = 1;
        tick();
        // R11 reset state
        chk("R11 cyc_type", int'(cyc_type), 0);
        chk("R11 dout_en", int'(dout_en), 0);
        chk("R11 rfsh_row", int'(rfsh_row), 0);
        chk("R11 seq_err", int'(seq_err), 0);

        // early write: row 2, column 5, data 0xA
        addr = 9'd2; ras_n = 0; tick();
        chk("R1 row-only type", int'(cyc_type), 4);
        chk("R1 row latched", int'(row_addr), 2);
        addr = 9'd5; we_n = 0; din = 4'hA; tick();
        cas_n = 0; tick();
        chk("R4 early write type", int'(cyc_type), 2);
        chk("R4 no drive", int'(dout_en), 0);
        chk("R4 column", int'(col_addr), 5);
        cas_n = 1; we_n = 1; tick();
        ras_n = 1; tick();
        chk("R8 standby", int'(cyc_type), 0);

        // read back, toggle OE, then read-modify-write
        addr = 9'd2; ras_n = 0; tick();
        addr = 9'd5; oe_n = 0; cas_n = 0; tick();
        chk("R3 read type", int'(cyc_type), 1);
        chk("R3 read data", int'(dout), 10);
        chk("R3 driven", int'(dout_en), 1);
        oe_n = 1; tick();
        chk("R3 OE rise releases", int'(dout_en), 0);
        oe_n = 0; tick();
        chk("R3 OE fall drives", int'(dout_en), 1);
        din = 4'h3; we_n = 0; tick();
        chk("R5 rmw type", int'(cyc_type), 3);
        chk("R5 old data kept", int'(dout), 10);
        oe_n = 1; cas_n = 1; we_n = 1; tick();
        ras_n = 1; tick();
        addr = 9'd2; ras_n = 0; tick();
        addr = 9'd5; oe_n = 0; cas_n = 0; tick(); tick();
        chk("R5 rmw stored", int'(dout), 3);
        cas_n = 1; oe_n = 1; tick();
        ras_n = 1; tick();

        // page mode in row 1
        addr = 9'd1; ras_n = 0; tick();
        addr = 9'd0; din = 4'h6; we_n = 0; tick();
        cas_n = 0; tick();
        cas_n = 1; tick();
        addr = 9'd1; din = 4'h7; tick();
        cas_n = 0; tick();
        chk("R7 second column", int'(col_addr), 1);
        cas_n = 1; we_n = 1; tick();
        addr = 9'd0; oe_n = 0; tick();
        cas_n = 0; tick();
        chk("R7 page read data", int'(dout), 6);
        chk("R7 same row", int'(row_addr), 1);
        cas_n = 1; oe_n = 1; tick();
        ras_n = 1; tick();

        // column-before-row refresh, then an illegal column strobe inside it
        cas_n = 0; tick();
        chk("R9 no error with row strobe high", int'(seq_err), 0);
        ras_n = 0; tick();
        chk("R2 cbr type", int'(cyc_type), 5);
        chk("R2 counter step", int'(rfsh_row), 1);
        cas_n = 1; tick();
        cas_n = 0; tick();
        chk("R9 error pulse", int'(seq_err), 1);
        tick();
        chk("R9 error one clock", int'(seq_err), 0);
        ras_n = 1; tick();
        chk("R8 standby after refresh", int'(cyc_type), 0);
        cas_n = 1; tick();

        // hidden refresh after a read of row 1 column 1
        addr = 9'd1; ras_n = 0; tick();
        oe_n = 0; cas_n = 0; tick(); tick();
        chk("R3 page-written data", int'(dout), 7);
        ras_n = 1; tick();
        chk("R6 drive held over row rise", int'(dout_en), 1);
        ras_n = 0; tick();
        chk("R6 hidden type", int'(cyc_type), 6);
        chk("R6 counter step", int'(rfsh_row), 2);
        chk("R6 data held", int'(dout), 7);
        chk("R6 drive held", int'(dout_en), 1);
        bus_busy = 1; tick();
        chk("R10 contention error", int'(seq_err), 1);
        bus_busy = 0; ras_n = 1; tick();
        cas_n = 1; oe_n = 1; tick();
        chk("R3 CAS rise releases", int'(dout_en), 0);

        // counter wrap
        for (int n = 0; n < 510; n++) begin
            cas_n = 0; tick();
            ras_n = 0; tick();
            ras_n = 1; tick();
            cas_n = 1; tick();
        end
        chk("R2 counter wraps to zero", int'(rfsh_row), 0);
        tick(); tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule